// File: doc/BRIEF.md
# Indexed USB Endpoint FIFO Access Unit

This block sits between a small 8-bit register bus and the byte buffers of a USB device's endpoints. Firmware writes an endpoint number into a select register. After that, one data register, one configuration register, a byte-count register and a pointer register all refer to that endpoint. Firmware drains OUT packets and fills IN packets one byte per access through the data register. The endpoint's pointer advances by itself after each access.

On the packet side, a simple engine pushes received bytes into an endpoint buffer. It then signals that the packet is complete. At that moment the endpoint's byte count is captured and stays frozen while firmware reads. A reset register holds individual endpoints in reset. Setting an endpoint's bit and then clearing it returns that endpoint to an empty state. The ping-pong bank indicator survives this reset.

Register map (3-bit `bus_addr`):

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | select | read/write | endpoint number |
| 1 | data | read/write | data port |
| 2 | configuration | read/write | see below |
| 3 | byte count | read-only | bits [6:0] |
| 4 | pointer | read-only | bits [6:0] |
| 5 | reset | read/write | bit n resets endpoint n |

Configuration register bits:

| Bit | Field | Access |
|---|---|---|
| 7 | enable | read/write |
| 6 | data toggle | read-only |
| 5 | ping-pong bank | read-only |
| 4 | sticky error | read-only |
| 3 | — | reads 0 |
| 2 | direction (1 = IN, 0 = OUT) | read/write |
| 1:0 | type (00 control, 01 interrupt, 10 bulk, 11 isochronous) | read/write |

Top module: `usb_ep_fifo_access`

## Requirements
- R1: Writing address 0 selects the endpoint used by addresses 1 to 4. Reading address 0 returns the selected number, and it reads 0 after reset.
- R2: Bytes pushed by the packet engine are stored in the endpoint's buffer. When the packet completes, the byte count (address 3) takes the number of bytes pushed since the last completion. Pushes and completions aimed at an endpoint that is disabled, in reset, or configured as non-control IN are ignored.
- R3: Reads of address 1 on an enabled OUT or control endpoint return the stored bytes in push order, one per read, and advance the pointer. Reads never change the byte count.
- R4: A data read with pointer equal to the byte count returns 0x00. It sets the endpoint's sticky error bit (configuration bit 4) and leaves the pointer unchanged.
- R5: A write to address 1 on an enabled IN or control endpoint stores the byte and increments the pointer. Once the pointer reaches 64, further writes are dropped, the error bit is set, and the pointer stays at 64.
- R6: While an endpoint's bit in the reset register (address 5, bit n for endpoint n) is 1, its pointer, byte count, data toggle and error bit are held at 0. Its bank bit and configuration are kept, and other endpoints are untouched.
- R7: The configuration register stores enable (bit 7), direction (bit 2, 1 = IN) and type (bits 1:0, 00 control, 01 interrupt, 10 bulk, 11 isochronous). It reads back with toggle in bit 6, bank in bit 5 and error in bit 4, and it is 0x00 after reset.
- R8: Data-port reads and writes to a disabled endpoint are ignored. A read returns 0x00, and the pointer and error bit do not change.
- R9: On a non-control endpoint, a data access against the configured direction is ignored: a read returns 0x00 and the pointer and error bit stay as they were. On a control endpoint both reads and writes are accepted.
- R10: Each accepted packet completion inverts the endpoint's data toggle and ping-pong bank bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pkt_ep | input | 2 | Endpoint addressed by the packet engine |
| pkt_push | input | 1 | Store `pkt_byte` into that endpoint's buffer |
| pkt_byte | input | 8 | Received byte |
| pkt_done | input | 1 | Packet complete on `pkt_ep` |

## Verification
Read data is registered, so `bus_rdata` carries a result in the cycle after the clock edge that samples `bus_rd`. Writes, pushes and packet completions take effect at the edge that samples them. Their effect is observed through a later read, which again returns one cycle after its own edge. The bench's driver pushes each expected value when it raises the read strobe. The monitor pops that value at the falling edge that follows the capturing rising edge, halfway into the cycle in which the result is valid.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    typedef enum logic [1:0] {
        EPK_CTRL = 2'b00,
        EPK_INTR = 2'b01,
        EPK_BULK = 2'b10,
        EPK_ISO  = 2'b11
    } ep_kind_e;

    typedef enum logic [2:0] {
        RA_SEL  = 3'd0,
        RA_DATA = 3'd1,
        RA_CFG  = 3'd2,
        RA_CNT  = 3'd3,
        RA_PTR  = 3'd4,
        RA_RST  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic     en;
        logic     dir_in;
        ep_kind_e kind;
    } ep_cfg_t;

endpackage

// File: rtl/ep_access_gate.sv
module ep_access_gate
    import usb_ep_pkg::*;
(
    input  ep_cfg_t cfg,
    input  logic    in_reset,
    output logic    rd_ok,
    output logic    wr_ok
);
    logic live;
    logic is_ctrl;

    always_comb begin
        live    = cfg.en && !in_reset;
        is_ctrl = (cfg.kind == EPK_CTRL);
        rd_ok   = live && (is_ctrl || !cfg.dir_in);
        wr_ok   = live && (is_ctrl || cfg.dir_in);
    end
endmodule

// File: rtl/ep_byte_store.sv
module ep_byte_store #(
    parameter int NUM_EP = 4,
    parameter int DEPTH  = 64,
    localparam int EP_W  = $clog2(NUM_EP),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             a_we,
    input  logic [EP_W-1:0]  a_ep,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [7:0]       a_data,
    input  logic             b_we,
    input  logic [EP_W-1:0]  b_ep,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [7:0]       b_data,
    input  logic [EP_W-1:0]  r_ep,
    input  logic [IDX_W-1:0] r_idx,
    output logic [7:0]       r_data
);
    localparam int WORDS = NUM_EP * DEPTH;
    localparam int AW    = $clog2(WORDS);

    logic [7:0] mem [WORDS];

    function automatic logic [AW-1:0] flat(input logic [EP_W-1:0] ep, input logic [IDX_W-1:0] idx);
        return AW'(ep) * AW'(DEPTH) + AW'(idx);
    endfunction

    always_ff @(posedge clk) begin
        if (a_we) mem[flat(a_ep, a_idx)] <= a_data;
        if (b_we) mem[flat(b_ep, b_idx)] <= b_data;
    end

    assign r_data = mem[flat(r_ep, r_idx)];
endmodule

// File: rtl/usb_ep_fifo_access.sv
module usb_ep_fifo_access
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int DEPTH  = 64,
    localparam int EP_W  = $clog2(NUM_EP),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic [EP_W-1:0] pkt_ep,
    input  logic            pkt_push,
    input  logic [7:0]      pkt_byte,
    input  logic            pkt_done
);
    typedef struct packed {
        logic [EP_W-1:0]               sel;
        ep_cfg_t [NUM_EP-1:0]          cfg;
        logic [NUM_EP-1:0][PTR_W-1:0]  ptr;
        logic [NUM_EP-1:0][PTR_W-1:0]  cnt;
        logic [NUM_EP-1:0][PTR_W-1:0]  fill;
        logic [NUM_EP-1:0]             tgl;
        logic [NUM_EP-1:0]             bank;
        logic [NUM_EP-1:0]             err;
        logic [NUM_EP-1:0]             rst;
        logic [7:0]                    rdata;
    } state_t;

    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    state_t st_d, st_q;

    logic [NUM_EP-1:0] rd_ok, wr_ok;
    logic              a_we, b_we;
    logic [IDX_W-1:0]  a_idx, b_idx;
    logic [7:0]        mem_rd;

    // signals observed by the bound checker
    logic [PTR_W-1:0] sel_ptr, sel_cnt;
    logic             sel_err, sel_rst, sel_en;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_gate
        ep_access_gate u_gate (
            .cfg     (st_q.cfg[g]),
            .in_reset(st_q.rst[g]),
            .rd_ok   (rd_ok[g]),
            .wr_ok   (wr_ok[g])
        );
    end

    ep_byte_store #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .a_we  (a_we),
        .a_ep  (pkt_ep),
        .a_idx (a_idx),
        .a_data(pkt_byte),
        .b_we  (b_we),
        .b_ep  (st_q.sel),
        .b_idx (b_idx),
        .b_data(bus_wdata),
        .r_ep  (st_q.sel),
        .r_idx (st_q.ptr[st_q.sel][IDX_W-1:0]),
        .r_data(mem_rd)
    );

    always_comb begin
        ep_cfg_t c;
        logic [EP_W-1:0] s;
        st_d  = st_q;
        s     = st_q.sel;
        c     = st_q.cfg[s];
        a_we  = 1'b0;
        b_we  = 1'b0;
        a_idx = st_q.fill[pkt_ep][IDX_W-1:0];
        b_idx = st_q.ptr[s][IDX_W-1:0];

        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                RA_SEL: st_d.sel = bus_wdata[EP_W-1:0];
                RA_CFG: st_d.cfg[s] = '{en: bus_wdata[7], dir_in: bus_wdata[2],
                                        kind: ep_kind_e'(bus_wdata[1:0])};
                RA_RST: st_d.rst = bus_wdata[NUM_EP-1:0];
                RA_DATA: if (wr_ok[s]) begin
                    if (st_q.ptr[s] < FULL) begin
                        b_we        = 1'b1;
                        st_d.ptr[s] = st_q.ptr[s] + 1'b1;
                    end else begin
                        st_d.err[s] = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (bus_rd) begin
            st_d.rdata = 8'h00;
            case (reg_addr_e'(bus_addr))
                RA_SEL: st_d.rdata = 8'(s);
                RA_CFG: st_d.rdata = {c.en, st_q.tgl[s], st_q.bank[s], st_q.err[s],
                                      1'b0, c.dir_in, c.kind};
                RA_CNT: st_d.rdata = 8'(st_q.cnt[s]);
                RA_PTR: st_d.rdata = 8'(st_q.ptr[s]);
                RA_RST: st_d.rdata = 8'(st_q.rst);
                RA_DATA: if (rd_ok[s]) begin
                    if (st_q.ptr[s] < st_q.cnt[s]) begin
                        st_d.rdata  = mem_rd;
                        st_d.ptr[s] = st_q.ptr[s] + 1'b1;
                    end else begin
                        st_d.err[s] = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (pkt_push && rd_ok[pkt_ep] && st_q.fill[pkt_ep] < FULL) begin
            a_we                = 1'b1;
            st_d.fill[pkt_ep]   = st_q.fill[pkt_ep] + 1'b1;
        end
        if (pkt_done && rd_ok[pkt_ep]) begin
            st_d.cnt[pkt_ep]  = st_d.fill[pkt_ep];
            st_d.fill[pkt_ep] = '0;
            st_d.ptr[pkt_ep]  = '0;
            st_d.tgl[pkt_ep]  = ~st_q.tgl[pkt_ep];
            st_d.bank[pkt_ep] = ~st_q.bank[pkt_ep];
        end

        for (int i = 0; i < NUM_EP; i++) begin
            if (st_q.rst[i]) begin
                st_d.ptr[i]  = '0;
                st_d.cnt[i]  = '0;
                st_d.fill[i] = '0;
                st_d.tgl[i]  = 1'b0;
                st_d.err[i]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign sel_ptr   = st_q.ptr[st_q.sel];
    assign sel_cnt   = st_q.cnt[st_q.sel];
    assign sel_err   = st_q.err[st_q.sel];
    assign sel_rst   = st_q.rst[st_q.sel];
    assign sel_en    = st_q.cfg[st_q.sel].en;
endmodule

// File: rtl/usb_ep_fifo_access_chk.sv
module usb_ep_fifo_access_chk #(
    parameter int DEPTH = 64,
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_rdata,
    input logic             pkt_done,
    input logic [PTR_W-1:0] sel_ptr,
    input logic [PTR_W-1:0] sel_cnt,
    input logic             sel_err,
    input logic             sel_rst,
    input logic             sel_en
);
    logic data_acc;
    assign data_acc = (bus_addr == 3'd1);

    // R3: a data read leaves the frozen byte count alone
    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && data_acc && !bus_wr && !pkt_done && !sel_rst |=> $stable(sel_cnt));

    // R4: reading at or past the count yields zero
    a_r4_overread_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && data_acc && (sel_ptr >= sel_cnt) |=> bus_rdata == 8'h00);

    // R5: pointer and count never pass the buffer size
    a_r5_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ptr <= PTR_W'(DEPTH)) && (sel_cnt <= PTR_W'(DEPTH)));

    // R6: an endpoint held in reset is empty on the next cycle
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rst && !(bus_wr && bus_addr == 3'd0) |=> sel_ptr == '0 && sel_cnt == '0 && !sel_err);

    // R8: data accesses to a disabled endpoint move nothing
    a_r8_disabled_still: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && (bus_rd ^ bus_wr) && !sel_en && !pkt_done && !sel_rst
        |=> $stable(sel_ptr) && $stable(sel_err));
endmodule

bind usb_ep_fifo_access usb_ep_fifo_access_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .pkt_done (pkt_done),
    .sel_ptr  (sel_ptr),
    .sel_cnt  (sel_cnt),
    .sel_err  (sel_err),
    .sel_rst  (sel_rst),
    .sel_en   (sel_en)
);

// File: tb/usb_ep_fifo_access_tb.sv
module usb_ep_fifo_access_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] pkt_ep = '0;
    logic       pkt_push = 1'b0, pkt_done = 1'b0;
    logic [7:0] pkt_byte = '0;

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    logic prev_rd = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    usb_ep_fifo_access u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pkt_ep(pkt_ep), .pkt_push(pkt_push), .pkt_byte(pkt_byte), .pkt_done(pkt_done)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk) bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk) bus_rd = 1'b0;
    endtask

    task automatic push(input logic [1:0] ep, input logic [7:0] b);
        pkt_ep = ep; pkt_byte = b; pkt_push = 1'b1;
        @(negedge clk) pkt_push = 1'b0;
    endtask

    task automatic done(input logic [1:0] ep);
        pkt_ep = ep; pkt_done = 1'b1;
        @(negedge clk) pkt_done = 1'b0;
    endtask

    // monitor: a read strobe captured at a rising edge is compared at the next falling edge
    always @(posedge clk) prev_rd <= bus_rd;

    initial forever begin
        @(negedge clk);
        if (prev_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (bus_rdata !== 8'h00) begin
            failures++;
            $display("FAIL R7 reset rdata: got %02h expected 00", bus_rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);

        rd(3'd0, 8'h00, "R1 select after reset");
        rd(3'd2, 8'h00, "R7 config after reset");
        rd(3'd3, 8'h00, "R2 count after reset");

        wr(3'd0, 8'h01); wr(3'd2, 8'h82);
        rd(3'd2, 8'h82, "R7 bulk OUT config");
        wr(3'd0, 8'h02); wr(3'd2, 8'h86);
        rd(3'd2, 8'h86, "R7 bulk IN config");
        rd(3'd0, 8'h02, "R1 select readback");
        wr(3'd0, 8'h03); wr(3'd2, 8'h80);

        push(2'd1, 8'hA1); push(2'd1, 8'hB2); push(2'd1, 8'hC3); done(2'd1);
        wr(3'd0, 8'h01);
        rd(3'd3, 8'h03, "R2 count after packet");
        rd(3'd2, 8'hE2, "R10 toggle and bank set");
        rd(3'd1, 8'hA1, "R3 first byte");
        rd(3'd1, 8'hB2, "R3 second byte");
        rd(3'd1, 8'hC3, "R3 third byte");
        rd(3'd3, 8'h03, "R3 count frozen");
        rd(3'd4, 8'h03, "R3 pointer advanced");
        rd(3'd1, 8'h00, "R4 over-read zero");
        rd(3'd2, 8'hF2, "R4 error flag set");
        rd(3'd4, 8'h03, "R4 pointer held");
        wr(3'd1, 8'h55);
        rd(3'd4, 8'h03, "R9 write to OUT ignored");

        push(2'd2, 8'h99); push(2'd2, 8'h98); done(2'd2);
        wr(3'd0, 8'h02);
        rd(3'd3, 8'h00, "R2 push to IN ignored");
        rd(3'd2, 8'h86, "R2 completion to IN ignored");
        wr(3'd1, 8'h11); wr(3'd1, 8'h22);
        rd(3'd4, 8'h02, "R5 pointer after two writes");
        rd(3'd1, 8'h00, "R9 read of IN returns zero");
        rd(3'd4, 8'h02, "R9 read of IN leaves pointer");
        rd(3'd2, 8'h86, "R9 read of IN leaves error clear");
        for (int i = 0; i < 62; i++) wr(3'd1, 8'(i));
        rd(3'd4, 8'h40, "R5 pointer at full");
        wr(3'd1, 8'hEE);
        rd(3'd4, 8'h40, "R5 pointer saturates");
        rd(3'd2, 8'h96, "R5 full write sets error");

        push(2'd3, 8'h5A); push(2'd3, 8'h6B); done(2'd3);
        wr(3'd0, 8'h03);
        rd(3'd3, 8'h02, "R9 control count");
        rd(3'd1, 8'h5A, "R9 control read");
        wr(3'd1, 8'h77);
        rd(3'd4, 8'h02, "R9 control write");
        rd(3'd2, 8'hE0, "R10 control toggle and bank");

        push(2'd0, 8'h44); done(2'd0);
        wr(3'd0, 8'h00);
        rd(3'd3, 8'h00, "R8 push to disabled ignored");
        rd(3'd1, 8'h00, "R8 disabled read zero");
        wr(3'd1, 8'h33);
        rd(3'd4, 8'h00, "R8 disabled pointer still");
        rd(3'd2, 8'h00, "R8 disabled no error");

        wr(3'd5, 8'h02);
        rd(3'd5, 8'h02, "R6 reset register readback");
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h01);
        rd(3'd3, 8'h00, "R6 count cleared");
        rd(3'd4, 8'h00, "R6 pointer cleared");
        rd(3'd2, 8'hA2, "R6 toggle and error cleared, bank kept");
        wr(3'd0, 8'h02);
        rd(3'd4, 8'h40, "R6 other endpoint untouched");

        push(2'd1, 8'h3C); done(2'd1);
        wr(3'd0, 8'h01);
        rd(3'd3, 8'h01, "R2 second packet count");
        rd(3'd2, 8'hC2, "R10 toggle set bank cleared");
        rd(3'd1, 8'h3C, "R3 second packet byte");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule